// File: doc/BRIEF.md
# Tagged Next-Line Prefetch Controller

This controller sits beside a cache and decides when the line that follows a referenced line should be fetched ahead of demand. It keeps one usage bit per cache index. A line brought in by a prefetch starts with its bit cleared, and a line brought in by a demand miss starts with its bit set. Every hit sets the bit. The first hit on a prefetched line turns its bit from zero to one, and that transition is what signals that the sequential stream has reached the line.

Two policies are available on a static select input. In the miss-only policy, each demand miss asks for the following line. In the tagged policy, a miss does the same, and a hit that flips a usage bit from zero to one also asks for the following line.

Requests leave on a valid/ready port. At most one prefetch is pending or outstanding at a time, and a request is dropped when the cache reports that the successor line is already resident. A request stays outstanding until a prefetch fill for the same line address returns.

Top module: `nlpf_ctrl`

## Requirements
- R1: After reset, `pf_valid` is 0 and every usage bit is 1, so a hit on a line that has seen no fill issues no request.
- R2: A fill with `fill_is_pf`=1 clears the usage bit of index `fill_addr[IDX_W-1:0]`. In the tagged policy (`mode_tagged`=1), the next hit on that index raises `pf_valid` one cycle after the lookup, with `pf_addr` equal to the lookup address plus one.
- R3: A second hit on a line whose bit was already set by an earlier hit issues no request.
- R4: A fill with `fill_is_pf`=0 sets the usage bit, so a later hit on that line issues no request.
- R5: Under either policy, a lookup with `lk_hit`=0 raises `pf_valid` one cycle later, with `pf_addr` equal to the lookup address plus one.
- R6: Under the miss-only policy (`mode_tagged`=0), a zero-to-one hit issues no request but still sets the bit. A later hit on that line under the tagged policy therefore issues no request either.
- R7: The successor address wraps modulo 2^ADDR_W, so all ones is followed by zero.
- R8: While a request is pending (`pf_valid`=1) or outstanding (accepted but not yet filled), new triggers are dropped and `pf_addr` is unchanged. Only a fill with `fill_is_pf`=1 and `fill_addr` equal to `pf_addr` ends the outstanding state.
- R9: A trigger whose lookup carries `lk_succ_hit`=1 issues no request.
- R10: While `pf_valid`=1 and `pf_ready`=0, `pf_valid` stays 1 and `pf_addr` is held. A handshake clears `pf_valid` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_tagged | input | 1 | 1 selects the tagged policy, 0 selects the miss-only policy |
| lk_valid | input | 1 | A cache lookup is present this cycle |
| lk_addr | input | ADDR_W | Line address of the lookup |
| lk_hit | input | 1 | The lookup hit in the cache |
| lk_succ_hit | input | 1 | The line at lk_addr+1 is already resident |
| fill_valid | input | 1 | A line is being written into the cache |
| fill_addr | input | ADDR_W | Line address of the fill |
| fill_is_pf | input | 1 | The fill is the return of a prefetch |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Lower level accepts the request |
| pf_addr | output | ADDR_W | Line address to prefetch |

## Verification
Hits are tried after a prefetch fill, after a demand fill and with no fill at all. These three cases show whether only a zero-to-one transition triggers a request. The same transition is repeated under both policies, which separates the policy gate from the bit update. Misses are issued while a request is pending, while it is outstanding, after a fill that does not match, and after the matching fill, which exposes any fault in the single-in-flight tracking. Further lookups use the all-ones address, set the successor-resident flag, or hold the request port stalled.

// File: rtl/nlpf_ctrl.sv
module nlpf_ctrl #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_tagged,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hit,
  input  logic              lk_succ_hit,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_is_pf,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  used;
  logic              outst;
  logic [IDX_W-1:0]  lk_idx, fill_idx;
  logic              first_use, trig, busy, launch, retire;
  logic [ADDR_W-1:0] succ;

  assign lk_idx    = lk_addr[IDX_W-1:0];
  assign fill_idx  = fill_addr[IDX_W-1:0];
  assign first_use = lk_valid && lk_hit && !used[lk_idx];
  assign trig      = lk_valid && (!lk_hit || (mode_tagged && first_use));
  assign busy      = pf_valid || outst;
  assign launch    = trig && !busy && !lk_succ_hit;
  assign succ      = lk_addr + ADDR_W'(1);
  assign retire    = outst && fill_valid && fill_is_pf && (fill_addr == pf_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '1;
    end else begin
      if (fill_valid) used[fill_idx] <= !fill_is_pf;
      if (lk_valid && lk_hit) used[lk_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
      outst    <= 1'b0;
    end else begin
      if (launch) begin
        pf_valid <= 1'b1;
        pf_addr  <= succ;
      end else if (pf_valid && pf_ready) begin
        pf_valid <= 1'b0;
        outst    <= 1'b1;
      end
      if (retire) outst <= 1'b0;
    end
  end

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  p_succ_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> pf_addr == ADDR_W'($past(lk_addr) + ADDR_W'(1)));

  p_resident_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(lk_valid) && !$past(lk_succ_hit));

  p_single_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> !$past(outst));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pf_valid && outst));
endmodule

// File: tb/nlpf_ctrl_test.sv
module nlpf_ctrl_test;
  localparam int AW = 16;
  logic clk = 0, rst_n = 0, mode_tagged = 1;
  logic lk_valid = 0, lk_hit = 0, lk_succ_hit = 0;
  logic [AW-1:0] lk_addr = '0, fill_addr = '0;
  logic fill_valid = 0, fill_is_pf = 0, pf_ready = 0;
  logic pf_valid;
  logic [AW-1:0] pf_addr;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  nlpf_ctrl #(.ADDR_W(AW), .IDX_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .mode_tagged(mode_tagged),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_succ_hit(lk_succ_hit),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_is_pf(fill_is_pf),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr));

  task automatic check(string req, logic [AW:0] act, logic [AW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(logic [AW-1:0] a, logic h, logic sh);
    lk_valid = 1; lk_addr = a; lk_hit = h; lk_succ_hit = sh;
    @(posedge clk); @(negedge clk);
    lk_valid = 0; lk_hit = 0; lk_succ_hit = 0;
  endtask

  task automatic fill(logic [AW-1:0] a, logic p);
    fill_valid = 1; fill_addr = a; fill_is_pf = p;
    @(posedge clk); @(negedge clk);
    fill_valid = 0; fill_is_pf = 0;
  endtask

  task automatic accept();
    pf_ready = 1;
    @(posedge clk); @(negedge clk);
    pf_ready = 0;
  endtask

  task automatic t_reset();
    check("R1 idle", {1'b0, 15'd0, pf_valid}, 17'd0);
    look(16'h0005, 1, 0);
    check("R1 no request", {1'b0, 15'd0, pf_valid}, 17'd0);
  endtask

  task automatic t_tagged();
    mode_tagged = 1;
    fill(16'h0010, 1);
    look(16'h0010, 1, 0);
    check("R2 request", {pf_valid, pf_addr}, {1'b1, 16'h0011});
    accept();
    check("R10 handshake clears", {1'b0, 15'd0, pf_valid}, 17'd0);
    fill(16'h0011, 1);
    look(16'h0010, 1, 0);
    check("R3 second hit", {1'b0, 15'd0, pf_valid}, 17'd0);
  endtask

  task automatic t_demand();
    fill(16'h0022, 0);
    look(16'h0022, 1, 0);
    check("R4 demand fill", {1'b0, 15'd0, pf_valid}, 17'd0);
  endtask

  task automatic t_miss_stall();
    look(16'h0030, 0, 0);
    check("R5 miss tagged", {pf_valid, pf_addr}, {1'b1, 16'h0031});
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      check("R10 stall hold", {pf_valid, pf_addr}, {1'b1, 16'h0031});
    end
    accept();
    fill(16'h0031, 1);
  endtask

  task automatic t_onmiss();
    mode_tagged = 0;
    fill(16'h0044, 1);
    look(16'h0044, 1, 0);
    check("R6 no trigger", {1'b0, 15'd0, pf_valid}, 17'd0);
    mode_tagged = 1;
    look(16'h0044, 1, 0);
    check("R6 bit was set", {1'b0, 15'd0, pf_valid}, 17'd0);
    mode_tagged = 0;
    look(16'h0050, 0, 0);
    check("R5 miss on-miss", {pf_valid, pf_addr}, {1'b1, 16'h0051});
    accept();
    fill(16'h0051, 1);
    mode_tagged = 1;
  endtask

  task automatic t_flight();
    look(16'hFFFF, 0, 0);
    check("R7 wrap", {pf_valid, pf_addr}, {1'b1, 16'h0000});
    accept();
    look(16'h0060, 0, 0);
    check("R8 outstanding drop", {1'b0, 15'd0, pf_valid}, 17'd0);
    fill(16'h0000, 0);
    look(16'h0061, 0, 0);
    check("R8 non-pf fill keeps busy", {1'b0, 15'd0, pf_valid}, 17'd0);
    fill(16'h0005, 1);
    look(16'h0061, 0, 0);
    check("R8 wrong addr keeps busy", {1'b0, 15'd0, pf_valid}, 17'd0);
    fill(16'h0000, 1);
    look(16'h0062, 0, 0);
    check("R8 freed", {pf_valid, pf_addr}, {1'b1, 16'h0063});
    look(16'h0070, 0, 0);
    check("R8 pending drop", {pf_valid, pf_addr}, {1'b1, 16'h0063});
    accept();
    fill(16'h0063, 1);
  endtask

  task automatic t_resident();
    look(16'h0080, 0, 1);
    check("R9 miss succ resident", {1'b0, 15'd0, pf_valid}, 17'd0);
    fill(16'h0090, 1);
    look(16'h0090, 1, 1);
    check("R9 hit succ resident", {1'b0, 15'd0, pf_valid}, 17'd0);
    look(16'h00A0, 0, 0);
    check("R5 after drops", {pf_valid, pf_addr}, {1'b1, 16'h00A1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tagged();
    t_demand();
    t_miss_stall();
    t_onmiss();
    t_flight();
    t_resident();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule